// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the fetch address for a program memory of 4096 instruction words. Once per clock it takes one decoded control operation and moves the program counter. It can step to the next address, jump or call inside a 1024-word page, return from a subroutine or an interrupt, enter the interrupt vector, or go back to the reset vector.

The return addresses live in an eight-entry hardware stack. A jump or a call supplies only the low ten address bits. The upper two bits come from a separate page-select input, which is normally a register that software writes. Sequential stepping carries through all twelve bits and leaves the page input out of the calculation.

When the stack is full, a further push overwrites the oldest entry in ring fashion and raises a one-cycle overflow flag. When the stack is empty, a pop leaves the counter where it is and raises a one-cycle underflow flag. The asynchronous reset is released through a two-stage synchronizer.

Top module: `fetch_addr_gen`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` is 0x000 and both flags are 0. The stack is empty after reset.
- R2: The operation code 3'd1 (step) sets the address to the old address plus one, modulo 4096. So 0xFFF is followed by 0x000.
- R3: The operation code 3'd2 (jump) sets the address to `{page_i, tgt_i}`, with `page_i` as bits 11:10 and `tgt_i` as bits 9:0.
- R4: The operation code 3'd3 (call) sets the address to `{page_i, tgt_i}` and pushes the old address plus one, modulo 4096.
- R5: The operation codes 3'd4 (return) and 3'd5 (interrupt return) load all twelve bits of the address from the most recently pushed entry and remove that entry.
- R6: The operation code 3'd6 (interrupt entry) sets the address to 0x008 and pushes the old address unchanged, because that instruction has not yet executed.
- R7: The operation code 3'd0 (hold) leaves the address and the stack unchanged.
- R8: The operation code 3'd7 (restart) sets the address to 0x000 and empties the stack.
- R9: A push made while eight entries are held overwrites the oldest entry. `ovf_o` is 1 for exactly the cycle after that push and 0 otherwise.
- R10: A return of either kind made while the stack is empty leaves the address unchanged. `unf_o` is 1 for exactly the cycle after it and 0 otherwise.
- R11: Entries come back in last-in first-out order across all eight levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Decoded control operation |
| tgt_i | input | 10 | In-page target for jump and call |
| page_i | input | 2 | Page select, address bits 11:10 for jump and call |
| fetch_addr_o | output | 12 | Registered fetch address |
| ovf_o | output | 1 | One-cycle stack overflow indication |
| unf_o | output | 1 | One-cycle stack underflow indication |

## Verification
Directed sequences run first:
- A jump to the top of the last page followed by a step, which separates a full twelve-bit carry from one that stops at the page boundary.
- Calls with page values that differ from the page of the current address, which show whether the upper bits come from the page input or from the old counter.
- Nine nested calls followed by nine returns, which check ring overwrite, overflow timing, last-in first-out order and the underflow on the final pop.
- Interrupt entry followed by an interrupt return, which separates a pushed current address from a pushed incremented address.

A long stream of random operations then mixes all eight codes, including restart with a partly filled stack, and checks against a queue-based model on every clock.

// File: rtl/fag_pkg.sv
package fag_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5,
    OP_IRQ  = 3'd6,
    OP_SRST = 3'd7
  } fag_op_e;
endpackage

// File: rtl/fag_rst_sync.sv
module fag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fag_stack.sv
module fag_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  // Storage: one write enable per entry, no reset on data
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && (wp_q == PW'(i))) mem[i] <= push_data;
    end
  end

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign top_data = mem[wp_q - PW'(1)];

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    en    = 1'b0;
    if (clr) begin
      wp_d  = '0;
      cnt_d = '0;
      en    = 1'b1;
    end else if (push) begin
      wp_d  = wp_q + PW'(1);
      cnt_d = full ? cnt_q : cnt_q + CW'(1);
      en    = 1'b1;
    end else if (pop && !empty) begin
      wp_d  = wp_q - PW'(1);
      cnt_d = cnt_q - CW'(1);
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fag_next.sv
module fag_next
  import fag_pkg::*;
#(
  parameter int          AW      = 12,
  parameter int          LW      = 10,
  parameter logic [AW-1:0] RST_VEC = '0,
  parameter logic [AW-1:0] IRQ_VEC = 12'h008
) (
  input  fag_op_e          op,
  input  logic [AW-1:0]    pc,
  input  logic [AW-LW-1:0] page,
  input  logic [LW-1:0]    tgt,
  input  logic [AW-1:0]    top_data,
  input  logic             empty,
  input  logic             full,
  output logic [AW-1:0]    pc_nxt,
  output logic             pc_en,
  output logic             push,
  output logic             pop,
  output logic             clr,
  output logic [AW-1:0]    push_data,
  output logic             ovf_set,
  output logic             unf_set
);
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] paged;

  assign pc_inc = pc + AW'(1);
  assign paged  = {page, tgt};

  always_comb begin
    pc_nxt    = pc;
    pc_en     = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    clr       = 1'b0;
    push_data = pc_inc;
    unf_set   = 1'b0;
    unique case (op)
      OP_HOLD: ;
      OP_STEP: begin pc_nxt = pc_inc; pc_en = 1'b1; end
      OP_JUMP: begin pc_nxt = paged;  pc_en = 1'b1; end
      OP_CALL: begin
        pc_nxt = paged; pc_en = 1'b1; push = 1'b1; push_data = pc_inc;
      end
      OP_IRQ: begin
        pc_nxt = IRQ_VEC; pc_en = 1'b1; push = 1'b1; push_data = pc;
      end
      OP_RET, OP_RETI: begin
        if (empty) unf_set = 1'b1;
        else begin pc_nxt = top_data; pc_en = 1'b1; pop = 1'b1; end
      end
      OP_SRST: begin pc_nxt = RST_VEC; pc_en = 1'b1; clr = 1'b1; end
      default: ;
    endcase
  end

  assign ovf_set = push && full;
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
  import fag_pkg::*;
#(
  parameter int AW    = 12,
  parameter int LW    = 10,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [LW-1:0]    tgt_i,
  input  logic [AW-LW-1:0] page_i,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [AW-1:0] RST_VEC = '0;
  localparam logic [AW-1:0] IRQ_VEC = AW'(8);

  logic          rst_sync_n;
  fag_op_e       op;
  logic [AW-1:0] pc_q, pc_nxt, top_data, push_data;
  logic          pc_en, push, pop, clr, empty, full, ovf_set, unf_set;
  logic          ovf_q, unf_q;

  assign op = fag_op_e'(op_i);

  fag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  fag_next #(.AW(AW), .LW(LW), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_next (
    .op(op), .pc(pc_q), .page(page_i), .tgt(tgt_i),
    .top_data(top_data), .empty(empty), .full(full),
    .pc_nxt(pc_nxt), .pc_en(pc_en), .push(push), .pop(pop), .clr(clr),
    .push_data(push_data), .ovf_set(ovf_set), .unf_set(unf_set)
  );

  fag_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .push(push), .pop(pop),
    .push_data(push_data), .top_data(top_data), .empty(empty), .full(full)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= RST_VEC;
    else if (pc_en)   pc_q <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set;
      unf_q <= unf_set;
    end
  end

  assign fetch_addr_o = pc_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
endmodule

// File: rtl/fag_checker.sv
module fag_checker
  import fag_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic [9:0]  tgt,
  input logic [1:0]  page,
  input logic [11:0] addr,
  input logic        ovf,
  input logic        unf
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_STEP |=> addr == $past(addr) + 12'd1);

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_JUMP |=> addr == {$past(page), $past(tgt)});

  p_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CALL |=> addr == {$past(page), $past(tgt)});

  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_IRQ |=> addr == 12'h008);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(addr) && !ovf && !unf);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SRST |=> addr == 12'h000 && !ovf && !unf);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(op) == OP_CALL || $past(op) == OP_IRQ));

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (($past(op) == OP_RET || $past(op) == OP_RETI) && $stable(addr)));
endmodule

bind fetch_addr_gen fag_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op(op_i), .tgt(tgt_i), .page(page_i),
  .addr(fetch_addr_o), .ovf(ovf_o), .unf(unf_o)
);

// File: tb/fetch_addr_gen_bench.sv
module fetch_addr_gen_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [9:0]  tgt;
  logic [1:0]  page;
  logic [11:0] addr;
  logic        ovf, unf;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [11:0] m_pc;
  logic        m_ovf, m_unf;
  logic [11:0] m_stk[$];

  fetch_addr_gen u_fetch_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_i(op), .tgt_i(tgt), .page_i(page),
    .fetch_addr_o(addr), .ovf_o(ovf), .unf_o(unf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string req);
    n_vec++;
    if (addr !== m_pc || ovf !== m_ovf || unf !== m_unf) begin
      n_bad++;
      $display("FAIL %s: addr=%h ovf=%b unf=%b expected addr=%h ovf=%b unf=%b",
               req, addr, ovf, unf, m_pc, m_ovf, m_unf);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [9:0] t, input logic [1:0] p);
    m_ovf = 1'b0;
    m_unf = 1'b0;
    case (o)
      3'd1: m_pc = m_pc + 12'd1;
      3'd2: m_pc = {p, t};
      3'd3, 3'd6: begin
        if (m_stk.size() == 8) begin
          void'(m_stk.pop_front());
          m_ovf = 1'b1;
        end
        m_stk.push_back(o == 3'd3 ? m_pc + 12'd1 : m_pc);
        m_pc = (o == 3'd3) ? {p, t} : 12'h008;
      end
      3'd4, 3'd5: begin
        if (m_stk.size() == 0) m_unf = 1'b1;
        else m_pc = m_stk.pop_back();
      end
      3'd7: begin m_pc = 12'h000; m_stk.delete(); end
      default: ;
    endcase
  endtask

  // Drive at negedge, model after posedge, compare at following negedge
  task automatic step(input logic [2:0] o, input logic [9:0] t,
                      input logic [1:0] p, input string req);
    op = o; tgt = t; page = p;
    @(posedge clk);
    model(o, t, p);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    rst_n = 1'b0; op = 3'd0; tgt = '0; page = '0;
    m_pc = '0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");
    // R1: stack empty after reset, so a return underflows
    step(3'd4, 10'h0, 2'd0, "R1");
    step(3'd1, 10'h0, 2'd0, "R2");
    step(3'd1, 10'h0, 2'd0, "R2");
    step(3'd0, 10'h155, 2'd3, "R7");
    step(3'd2, 10'h3FF, 2'd3, "R3");
    step(3'd1, 10'h0, 2'd0, "R2");   // 0xFFF -> 0x000
    step(3'd2, 10'h2A5, 2'd1, "R3");
    step(3'd2, 10'h3FF, 2'd0, "R3");
    step(3'd1, 10'h0, 2'd2, "R2");   // 0x3FF -> 0x400, page input ignored
    step(3'd3, 10'h010, 2'd2, "R4");
    step(3'd1, 10'h0, 2'd0, "R2");
    step(3'd4, 10'h0, 2'd0, "R5");
    step(3'd6, 10'h0, 2'd0, "R6");
    step(3'd1, 10'h0, 2'd0, "R6");
    step(3'd5, 10'h0, 2'd0, "R5");
    // R9, R11: nine nested calls then nine returns
    for (int i = 0; i < 9; i++) step(3'd3, 10'(i * 37 + 5), 2'(i), "R9");
    step(3'd0, 10'h0, 2'd0, "R9");
    for (int i = 0; i < 8; i++) step((i % 2) ? 3'd5 : 3'd4, 10'h0, 2'd0, "R11");
    step(3'd4, 10'h0, 2'd0, "R10");
    step(3'd5, 10'h0, 2'd0, "R10");
    step(3'd0, 10'h0, 2'd0, "R10");
    step(3'd3, 10'h123, 2'd1, "R4");
    step(3'd6, 10'h0, 2'd0, "R6");
    step(3'd7, 10'h0, 2'd0, "R8");
    step(3'd4, 10'h0, 2'd0, "R8");
    for (int i = 0; i < 3000; i++)
      step(3'($urandom_range(0, 7)), 10'($urandom), 2'($urandom), "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule